// File: doc/BRIEF.md
# Interruption Arbiter and Status-Word Exchange

This block sits beside the instruction engine of a processor and decides when normal execution is suspended. Five interruption classes can raise events: machine check, program exception, supervisor call, external and I/O. Each event is latched as pending. Masks in the current 64-bit program status word (PSW) gate the external and I/O classes, and the program class is gated as each exception arrives. A fixed priority then chooses one winner at a time.

For the winner, the block builds the old PSW. This is the current PSW with a 16-bit interruption code inserted and, for some classes, a new instruction length code (ILC). The block writes the old PSW as one aligned doubleword to the class's old-PSW slot in storage. It then reads the new PSW from the class's new-PSW slot. The value it reads becomes the current PSW.

Storage is reached through a single-port request channel with valid/ready handshake. A request stays asserted with constant address, direction and write data until the cycle in which `mem_req_ready` is high. Read data returns on `mem_rsp_valid` some cycles later. The block always accepts a response, so there is no back-pressure on the response path. Software and the execution engine set the PSW through `psw_wr`.

Top module: `isw_top`

## Requirements
- R1: The old/new PSW byte addresses are fixed per class: machine check 0x30/0x70, program 0x28/0x68, supervisor call 0x20/0x60, external 0x18/0x58, I/O 0x38/0x78.
- R2: Among enabled pending classes, the winner is chosen in this order: machine check, then program, then supervisor call, then external, then I/O. When a program exception and a supervisor call are pending together, the program exception is taken first.
- R3: PSW bit numbering puts bit 0 at the MSB, so PSW bit n is vector bit 63-n. For an I/O event whose channel is `io_addr[15:8]`, channels 0 to 5 are enabled by PSW bits 0 to 5. Channels 6 and above are all enabled by PSW bit 6.
- R4: External events are enabled by PSW bit 7. The source bits of successive `ext_evt` pulses are ORed while the external class is pending. Its code is {8'h00, accumulated sources}.
- R5: Program exception codes 8, 10, 13 and 14 are gated by PSW bits 36, 37, 38 and 39 respectively. A gated exception whose bit is 0 at arrival is discarded and never causes an interruption. All other program codes are always taken.
- R6: The stored old PSW equals the current PSW with bits 16 to 31 (vector [47:32]) replaced by the code. The codes are: I/O uses `io_addr`; program uses {8'h00, code}; supervisor call uses {8'h00, number}; external uses the accumulated sources; machine check uses 0. ILC bits 32 to 33 (vector [31:30]) become `pgm_ilc` for a program exception, or 0 when it is imprecise. They become 01 for a supervisor call. They are unchanged for the other classes.
- R7: Each exchange issues exactly one 64-bit write, to the old slot, and then exactly one read, from the new slot. The read is issued only after the write has been accepted.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, direction and write data stay unchanged on the next cycle.
- R9: `psw_loaded` pulses for one cycle, one cycle after `mem_rsp_valid`. From that cycle on, `psw_out` equals the read data. `busy` is high from the cycle an interruption is taken until the load, and no second interruption starts while it is high.
- R10: A masked I/O or external event stays pending. It is taken once a later PSW write enables it.
- R11: `psw_wr` updates `psw_out` on the next cycle when `busy` is low. It is ignored while `busy` is high.
- R12: After reset, nothing is pending, `psw_out` is zero, no storage request is issued and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psw_wr | input | 1 | Load current PSW from `psw_wr_data` |
| psw_wr_data | input | 64 | New current PSW value |
| mck_evt | input | 1 | Machine check event pulse |
| pgm_evt | input | 1 | Program exception event pulse |
| pgm_code | input | 8 | Program exception number |
| pgm_ilc | input | 2 | Instruction length code of the faulting instruction |
| pgm_imprecise | input | 1 | Exception is imprecise (ILC stored as 0) |
| svc_evt | input | 1 | Supervisor call event pulse |
| svc_num | input | 8 | Supervisor call number |
| ext_evt | input | 1 | External event pulse |
| ext_src | input | 8 | External source bits |
| io_evt | input | 1 | I/O event pulse |
| io_addr | input | 16 | Channel (high byte) and device (low byte) |
| mem_req_valid | output | 1 | Storage request valid |
| mem_req_ready | input | 1 | Storage accepts request this cycle |
| mem_req_write | output | 1 | 1 = write doubleword, 0 = read |
| mem_req_addr | output | 24 | Byte address (doubleword aligned) |
| mem_req_wdata | output | 64 | Write data (old PSW) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 64 | Read data (new PSW) |
| busy | output | 1 | Exchange in progress or starting |
| psw_loaded | output | 1 | One-cycle pulse: new PSW installed |
| psw_out | output | 64 | Current PSW |

## Verification
The bench sweeps every system-mask byte against every channel number. If bit 6 were not shared for channels 6 and up, or the bit order were reversed, the wrong I/O events would be taken. It also crosses every program code with every program-mask nibble. A design that mapped the four gated codes to the wrong mask bits would take or drop the wrong exceptions, and one that latched masked exceptions would take them later.

All 31 combinations of simultaneous events check the service order and the slot addresses. Rendering the priority wrongly, or letting the read overtake the write, shows up as misordered fetch addresses or in the write/read counts. Masked I/O and external events are checked to survive until a later PSW write enables them; a design that dropped them would never load. A PSW write during an exchange is checked to be ignored; a design that accepted it would corrupt `psw_out`. Random ready stalls throughout stress the request hold rule.

// File: rtl/isw_pkg.sv
package isw_pkg;

  localparam int PSW_W  = 64;
  localparam int CODE_W = 16;
  localparam int NCLS   = 5;

  // Position in this enum is the fixed service priority (0 = highest).
  typedef enum logic [2:0] {
    CL_MCK = 3'd0,
    CL_PGM = 3'd1,
    CL_SVC = 3'd2,
    CL_EXT = 3'd3,
    CL_IO  = 3'd4
  } icls_t;

  // Old-PSW slot per class; the new-PSW slot is always 0x40 above it.
  function automatic logic [7:0] old_slot(input icls_t c);
    case (c)
      CL_MCK:  return 8'h30;
      CL_PGM:  return 8'h28;
      CL_SVC:  return 8'h20;
      CL_EXT:  return 8'h18;
      default: return 8'h38;
    endcase
  endfunction

  function automatic logic [7:0] new_slot(input icls_t c);
    return old_slot(c) | 8'h40;
  endfunction

  // PSW bits are numbered from the MSB.
  function automatic logic psw_bit(input logic [PSW_W-1:0] p, input int n);
    return p[PSW_W-1-n];
  endfunction

endpackage

// File: rtl/isw_arbiter.sv
module isw_arbiter
  import isw_pkg::*;
#(
  parameter int DIRECT_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PSW_W-1:0]  psw,
  input  logic              pend_mck,
  input  logic              pend_pgm,
  input  logic [7:0]        pgm_code_q,
  input  logic [1:0]        pgm_ilc_q,
  input  logic              pend_svc,
  input  logic [7:0]        svc_num_q,
  input  logic [7:0]        pend_ext,
  input  logic              pend_io,
  input  logic [15:0]       io_addr_q,
  output logic              win_valid,
  output icls_t             win_cls,
  output logic [CODE_W-1:0] win_code,
  output logic              win_ilc_set,
  output logic [1:0]        win_ilc
);

  localparam int EXT_MASK_BIT = 7;

  logic [NCLS-1:0] req;
  logic [NCLS-1:0] grant;
  logic            io_en;
  logic [7:0]      io_ch;

  assign io_ch = io_addr_q[15:8];

  always_comb begin
    if (int'(io_ch) < DIRECT_CH) io_en = psw_bit(psw, int'(io_ch));
    else                         io_en = psw_bit(psw, DIRECT_CH);
  end

  always_comb begin
    req              = '0;
    req[int'(CL_MCK)] = pend_mck;
    req[int'(CL_PGM)] = pend_pgm;
    req[int'(CL_SVC)] = pend_svc;
    req[int'(CL_EXT)] = (|pend_ext) && psw_bit(psw, EXT_MASK_BIT);
    req[int'(CL_IO)]  = pend_io && io_en;
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    grant   = '0;
    win_cls = CL_MCK;
    for (int i = 0; i < NCLS; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        win_cls  = icls_t'(i[2:0]);
        found    = 1'b1;
      end
    end
  end

  assign win_valid = |grant;

  always_comb begin
    win_ilc_set = 1'b0;
    win_ilc     = 2'b00;
    case (win_cls)
      CL_PGM: begin
        win_code    = {8'h00, pgm_code_q};
        win_ilc_set = 1'b1;
        win_ilc     = pgm_ilc_q;
      end
      CL_SVC: begin
        win_code    = {8'h00, svc_num_q};
        win_ilc_set = 1'b1;
        win_ilc     = 2'b01;
      end
      CL_EXT:  win_code = {8'h00, pend_ext};
      CL_IO:   win_code = io_addr_q;
      default: win_code = '0;
    endcase
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2
  mck_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_mck |-> (win_valid && win_cls == CL_MCK));

endmodule

// File: rtl/isw_swap_seq.sv
module isw_swap_seq
  import isw_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  icls_t            start_cls,
  input  logic [PSW_W-1:0] start_old,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [AW-1:0]    mem_req_addr,
  output logic [PSW_W-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [PSW_W-1:0] mem_rsp_rdata,
  output logic             seq_busy,
  output logic             load_en,
  output logic [PSW_W-1:0] load_data,
  output logic             loaded
);

  typedef enum logic [1:0] {S_IDLE, S_STORE, S_FETCH, S_WAIT} sstate_t;

  sstate_t          st;
  icls_t            cls_q;
  logic [PSW_W-1:0] old_q;
  logic             fire;

  assign fire          = mem_req_valid && mem_req_ready;
  assign mem_req_valid = (st == S_STORE) || (st == S_FETCH);
  assign mem_req_write = (st == S_STORE);
  assign mem_req_addr  = (st == S_STORE) ? AW'(old_slot(cls_q)) : AW'(new_slot(cls_q));
  assign mem_req_wdata = old_q;
  assign seq_busy      = (st != S_IDLE);
  assign load_en       = (st == S_WAIT) && mem_rsp_valid;
  assign load_data     = mem_rsp_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cls_q  <= CL_MCK;
      old_q  <= '0;
      loaded <= 1'b0;
    end else begin
      loaded <= load_en;
      case (st)
        S_IDLE: if (start) begin
          st    <= S_STORE;
          cls_q <= start_cls;
          old_q <= start_old;
        end
        S_STORE: if (fire) st <= S_FETCH;
        S_FETCH: if (fire) st <= S_WAIT;
        default: if (mem_rsp_valid) st <= S_IDLE;
      endcase
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_req_valid && !mem_req_ready) |->
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  // R9
  load_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |-> $past(mem_rsp_valid));

  // R7
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !seq_busy);

  // R7
  read_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mem_req_write) |=> (mem_req_valid && !mem_req_write));

endmodule

// File: rtl/isw_top.sv
module isw_top
  import isw_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DIRECT_CH = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psw_wr,
  input  logic [63:0] psw_wr_data,
  input  logic        mck_evt,
  input  logic        pgm_evt,
  input  logic [7:0]  pgm_code,
  input  logic [1:0]  pgm_ilc,
  input  logic        pgm_imprecise,
  input  logic        svc_evt,
  input  logic [7:0]  svc_num,
  input  logic        ext_evt,
  input  logic [7:0]  ext_src,
  input  logic        io_evt,
  input  logic [15:0] io_addr,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [63:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_rdata,
  output logic        busy,
  output logic        psw_loaded,
  output logic [63:0] psw_out
);

  localparam int PM_BASE = 36;
  localparam int CODE_LO = PSW_W - 1 - 31;
  localparam int ILC_LO  = PSW_W - 1 - 33;

  logic [PSW_W-1:0]  cur_psw;
  logic              pend_mck, pend_pgm, pend_svc, pend_io;
  logic [7:0]        pend_ext;
  logic [7:0]        pgm_code_q, svc_num_q;
  logic [1:0]        pgm_ilc_q;
  logic [15:0]       io_addr_q;
  logic              win_valid, win_ilc_set;
  icls_t             win_cls;
  logic [CODE_W-1:0] win_code;
  logic [1:0]        win_ilc;
  logic              seq_busy, take, load_en;
  logic [PSW_W-1:0]  load_data, old_psw;
  logic              pgm_allowed;

  // Gated program exceptions map onto consecutive program-mask bits.
  always_comb begin
    case (pgm_code)
      8'd8:    pgm_allowed = psw_bit(cur_psw, PM_BASE + 0);
      8'd10:   pgm_allowed = psw_bit(cur_psw, PM_BASE + 1);
      8'd13:   pgm_allowed = psw_bit(cur_psw, PM_BASE + 2);
      8'd14:   pgm_allowed = psw_bit(cur_psw, PM_BASE + 3);
      default: pgm_allowed = 1'b1;
    endcase
  end

  assign take = win_valid && !seq_busy;
  assign busy = seq_busy || take;

  always_comb begin
    old_psw = cur_psw;
    old_psw[CODE_LO +: CODE_W] = win_code;
    if (win_ilc_set) old_psw[ILC_LO +: 2] = win_ilc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_psw    <= '0;
      pend_mck   <= 1'b0;
      pend_pgm   <= 1'b0;
      pend_svc   <= 1'b0;
      pend_io    <= 1'b0;
      pend_ext   <= '0;
      pgm_code_q <= '0;
      pgm_ilc_q  <= '0;
      svc_num_q  <= '0;
      io_addr_q  <= '0;
    end else begin
      if (load_en)              cur_psw <= load_data;
      else if (psw_wr && !busy) cur_psw <= psw_wr_data;

      pend_mck <= (pend_mck && !(take && win_cls == CL_MCK)) || mck_evt;

      if (pgm_evt && pgm_allowed && (!pend_pgm || (take && win_cls == CL_PGM))) begin
        pend_pgm   <= 1'b1;
        pgm_code_q <= pgm_code;
        pgm_ilc_q  <= pgm_imprecise ? 2'b00 : pgm_ilc;
      end else if (take && win_cls == CL_PGM) begin
        pend_pgm <= 1'b0;
      end

      if (svc_evt && (!pend_svc || (take && win_cls == CL_SVC))) begin
        pend_svc  <= 1'b1;
        svc_num_q <= svc_num;
      end else if (take && win_cls == CL_SVC) begin
        pend_svc <= 1'b0;
      end

      pend_ext <= ((take && win_cls == CL_EXT) ? 8'h00 : pend_ext) | (ext_evt ? ext_src : 8'h00);

      if (io_evt && (!pend_io || (take && win_cls == CL_IO))) begin
        pend_io   <= 1'b1;
        io_addr_q <= io_addr;
      end else if (take && win_cls == CL_IO) begin
        pend_io <= 1'b0;
      end
    end
  end

  isw_arbiter #(.DIRECT_CH(DIRECT_CH)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .psw        (cur_psw),
    .pend_mck   (pend_mck),
    .pend_pgm   (pend_pgm),
    .pgm_code_q (pgm_code_q),
    .pgm_ilc_q  (pgm_ilc_q),
    .pend_svc   (pend_svc),
    .svc_num_q  (svc_num_q),
    .pend_ext   (pend_ext),
    .pend_io    (pend_io),
    .io_addr_q  (io_addr_q),
    .win_valid  (win_valid),
    .win_cls    (win_cls),
    .win_code   (win_code),
    .win_ilc_set(win_ilc_set),
    .win_ilc    (win_ilc)
  );

  isw_swap_seq #(.AW(AW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (take),
    .start_cls    (win_cls),
    .start_old    (old_psw),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata),
    .seq_busy     (seq_busy),
    .load_en      (load_en),
    .load_data    (load_data),
    .loaded       (psw_loaded)
  );

  assign psw_out = cur_psw;

  // R11
  psw_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_busy) && !psw_loaded) |-> $stable(psw_out));

  // R9
  loaded_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psw_loaded |=> !psw_loaded);

endmodule

// File: tb/isw_top_bench.sv
module isw_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psw_wr = 1'b0;
  logic [63:0] psw_wr_data = '0;
  logic        mck_evt = 1'b0, pgm_evt = 1'b0, svc_evt = 1'b0, ext_evt = 1'b0, io_evt = 1'b0;
  logic [7:0]  pgm_code = '0, svc_num = '0, ext_src = '0;
  logic [1:0]  pgm_ilc = '0;
  logic        pgm_imprecise = 1'b0;
  logic [15:0] io_addr = '0;
  logic        mem_req_valid, mem_req_ready, mem_req_write, busy, psw_loaded;
  logic [23:0] mem_req_addr;
  logic [63:0] mem_req_wdata, psw_out;
  logic        rsp_v;
  logic [63:0] rsp_d;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  isw_top u_isw_top (
    .clk(clk), .rst_n(rst_n), .psw_wr(psw_wr), .psw_wr_data(psw_wr_data),
    .mck_evt(mck_evt), .pgm_evt(pgm_evt), .pgm_code(pgm_code), .pgm_ilc(pgm_ilc),
    .pgm_imprecise(pgm_imprecise), .svc_evt(svc_evt), .svc_num(svc_num),
    .ext_evt(ext_evt), .ext_src(ext_src), .io_evt(io_evt), .io_addr(io_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(rsp_v), .mem_rsp_rdata(rsp_d),
    .busy(busy), .psw_loaded(psw_loaded), .psw_out(psw_out)
  );

  function automatic logic [63:0] memf(input logic [7:0] a);
    return 64'hFF00_0000_0F00_0000 | {56'd0, a};
  endfunction

  function automatic logic [63:0] mkpsw(input logic [7:0] sm, input logic [3:0] pm);
    return {sm, 8'hA5, 16'h0000, 2'b11, 2'b00, pm, 24'h00BEEF};
  endfunction

  function automatic logic [63:0] with_code(input logic [63:0] p, input logic [15:0] c);
    logic [63:0] r;
    r = p;
    r[47:32] = c;
    return r;
  endfunction

  // Storage model with pseudo-random ready and one-cycle read latency.
  logic [7:0]  lfsr;
  logic [7:0]  st_a, fe_a;
  logic [63:0] st_d;
  int          wc, rc, nload;
  logic        ord;
  logic [7:0]  lg_st [16];
  logic [7:0]  lg_fe [16];
  logic [63:0] lg_sd [16];
  logic [63:0] lg_ps [16];
  int          lg_wc [16];
  int          lg_rc [16];
  logic        lg_or [16];

  assign mem_req_ready = lfsr[0] | lfsr[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 8'h5A; rsp_v <= 1'b0; rsp_d <= '0; wc <= 0; rc <= 0; nload <= 0;
      st_a <= '0; fe_a <= '0; st_d <= '0; ord <= 1'b0;
    end else begin
      lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rsp_v <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          st_a <= mem_req_addr[7:0]; st_d <= mem_req_wdata; wc <= wc + 1;
        end else begin
          fe_a <= mem_req_addr[7:0]; rc <= rc + 1; ord <= (wc != 0);
          rsp_v <= 1'b1; rsp_d <= memf(mem_req_addr[7:0]);
        end
      end
      if (psw_loaded) begin
        lg_st[nload % 16] <= st_a; lg_fe[nload % 16] <= fe_a; lg_sd[nload % 16] <= st_d;
        lg_ps[nload % 16] <= psw_out; lg_wc[nload % 16] <= wc; lg_rc[nload % 16] <= rc;
        lg_or[nload % 16] <= ord;
        nload <= nload + 1; wc <= 0; rc <= 0;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_psw(input logic [63:0] v);
    @(negedge clk); psw_wr = 1'b1; psw_wr_data = v;
    @(negedge clk); psw_wr = 1'b0;
  endtask

  task automatic wait_load(input int n0, output logic ok);
    int t;
    t = 0;
    while (nload <= n0 && t < 300) begin @(negedge clk); t++; end
    ok = (nload > n0);
    chk(ok, "R9 load completes", 64'(nload), 64'(n0 + 1));
  endtask

  // Verify one exchange record against expected class slot and old PSW.
  task automatic chk_rec(input int idx, input logic [7:0] oslot, input logic [63:0] oexp, input string req);
    int k;
    k = idx % 16;
    chk(lg_st[k] == oslot, "R1 old slot", 64'(lg_st[k]), 64'(oslot));
    chk(lg_fe[k] == (oslot | 8'h40), "R1 new slot", 64'(lg_fe[k]), 64'(oslot | 8'h40));
    chk(lg_sd[k] == oexp, req, lg_sd[k], oexp);
    chk(lg_wc[k] == 1 && lg_rc[k] == 1 && lg_or[k], "R7 one write then one read",
        64'(lg_wc[k] * 16 + lg_rc[k]), 64'h11);
    chk(lg_ps[k] == memf(oslot | 8'h40), "R9 loaded PSW", lg_ps[k], memf(oslot | 8'h40));
  endtask

  initial begin
    logic ok;
    int   n0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !mem_req_valid && !psw_loaded, "R12 idle after reset", {61'd0, busy, mem_req_valid, psw_loaded}, 64'd0);
    chk(psw_out == 64'd0, "R12 psw zero", psw_out, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_req_valid, "R12 no request", {62'd0, busy, mem_req_valid}, 64'd0);

    // R11 write while idle
    set_psw(mkpsw(8'h00, 4'h0));
    chk(psw_out == mkpsw(8'h00, 4'h0), "R11 psw write", psw_out, mkpsw(8'h00, 4'h0));

    // R3 / R10 sweep: every system mask against every channel group
    for (int ch = 0; ch < 8; ch++) begin
      for (int m = 0; m < 256; m++) begin
        logic [7:0]  sm;
        logic [15:0] ia;
        logic        en;
        sm = 8'(m);
        ia = {8'(ch), 8'(ch * 17 + 3)};
        en = (ch < 6) ? sm[7 - ch] : sm[1];
        set_psw(mkpsw(sm, 4'h0));
        n0 = nload;
        @(negedge clk); io_evt = 1'b1; io_addr = ia;
        @(negedge clk); io_evt = 1'b0;
        repeat (4) @(negedge clk);
        if (en) begin
          wait_load(n0, ok);
          if (ok) chk_rec(n0, 8'h38, with_code(mkpsw(sm, 4'h0), ia), "R6 R3 io old PSW");
        end else begin
          chk(nload == n0 && !busy, "R3 masked io not taken", 64'(nload - n0), 64'd0);
          // R10 enabling later takes the held event
          set_psw(mkpsw(8'hFF, 4'h0));
          wait_load(n0, ok);
          if (ok) chk_rec(n0, 8'h38, with_code(mkpsw(8'hFF, 4'h0), ia), "R10 held io taken");
        end
      end
    end

    // R5 / R6 program mask sweep
    for (int c = 1; c < 16; c++) begin
      for (int pm = 0; pm < 16; pm++) begin
        logic [3:0]  pmv;
        logic        en, impr;
        logic [63:0] exp;
        pmv  = 4'(pm);
        impr = pmv[0] ^ c[0];
        case (c)
          8:       en = pmv[3];
          10:      en = pmv[2];
          13:      en = pmv[1];
          14:      en = pmv[0];
          default: en = 1'b1;
        endcase
        set_psw(mkpsw(8'h00, pmv));
        n0 = nload;
        @(negedge clk); pgm_evt = 1'b1; pgm_code = 8'(c); pgm_ilc = 2'(c); pgm_imprecise = impr;
        @(negedge clk); pgm_evt = 1'b0;
        repeat (4) @(negedge clk);
        if (en) begin
          wait_load(n0, ok);
          exp = with_code(mkpsw(8'h00, pmv), {8'h00, 8'(c)});
          exp[31:30] = impr ? 2'b00 : 2'(c);
          if (ok) chk_rec(n0, 8'h28, exp, "R6 R5 program old PSW");
        end else begin
          chk(nload == n0 && !busy, "R5 masked program dropped", 64'(nload - n0), 64'd0);
          set_psw(mkpsw(8'h00, 4'hF));
          repeat (6) @(negedge clk);
          chk(nload == n0 && !busy, "R5 dropped program stays gone", 64'(nload - n0), 64'd0);
        end
      end
    end

    // R4 external: masked, accumulated, then enabled
    set_psw(mkpsw(8'hFE, 4'h0));
    n0 = nload;
    @(negedge clk); ext_evt = 1'b1; ext_src = 8'h81;
    @(negedge clk); ext_src = 8'h24;
    @(negedge clk); ext_evt = 1'b0;
    repeat (5) @(negedge clk);
    chk(nload == n0 && !busy, "R4 external masked", 64'(nload - n0), 64'd0);
    set_psw(mkpsw(8'h01, 4'h0));
    wait_load(n0, ok);
    if (ok) chk_rec(n0, 8'h18, with_code(mkpsw(8'h01, 4'h0), 16'h00A5), "R4 external code");

    // R6 supervisor call ILC, R11 write ignored while busy
    set_psw(mkpsw(8'h00, 4'h0));
    n0 = nload;
    @(negedge clk); svc_evt = 1'b1; svc_num = 8'h37;
    @(negedge clk); svc_evt = 1'b0;
    @(negedge clk);
    chk(busy, "R9 busy during exchange", 64'(busy), 64'd1);
    psw_wr = 1'b1; psw_wr_data = 64'hDEAD_BEEF_0000_1111;
    @(negedge clk); psw_wr = 1'b0;
    begin
      logic [63:0] e;
      e = with_code(mkpsw(8'h00, 4'h0), 16'h0037);
      e[31:30] = 2'b01;
      wait_load(n0, ok);
      if (ok) chk_rec(n0, 8'h20, e, "R6 svc old PSW");
    end
    chk(psw_out == memf(8'h60), "R11 write during busy ignored", psw_out, memf(8'h60));

    // R2 every combination of simultaneous events
    for (int s = 1; s < 32; s++) begin
      logic [4:0] sv;
      int         k;
      logic [7:0] ord_slot [5];
      sv = 5'(s);
      ord_slot[0] = 8'h30; ord_slot[1] = 8'h28; ord_slot[2] = 8'h20;
      ord_slot[3] = 8'h18; ord_slot[4] = 8'h38;
      set_psw(mkpsw(8'hFF, 4'hF));
      n0 = nload;
      @(negedge clk);
      mck_evt = sv[0]; pgm_evt = sv[1]; pgm_code = 8'd8; pgm_ilc = 2'b10; pgm_imprecise = 1'b0;
      svc_evt = sv[2]; svc_num = 8'h11; ext_evt = sv[3]; ext_src = 8'h02;
      io_evt = sv[4]; io_addr = 16'h0301;
      @(negedge clk);
      mck_evt = 1'b0; pgm_evt = 1'b0; svc_evt = 1'b0; ext_evt = 1'b0; io_evt = 1'b0;
      k = 0;
      for (int i = 0; i < 5; i++) begin
        if (sv[i]) begin
          wait_load(n0 + k, ok);
          if (ok) chk(lg_fe[(n0 + k) % 16] == (ord_slot[i] | 8'h40), "R2 service order",
                      64'(lg_fe[(n0 + k) % 16]), 64'(ord_slot[i] | 8'h40));
          k++;
        end
      end
      repeat (4) @(negedge clk);
      chk(nload == n0 + k && !busy, "R2 no extra exchange", 64'(nload - n0), 64'(k));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    vectors++;
    $display("FAIL watchdog R9 actual=%h expected=%h", 64'd1, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule